// File: doc/BRIEF.md
# RAM Error Logging and Interrupt Unit

This block sits beside a tightly coupled RAM whose ECC and address-parity logic lives elsewhere. Each cycle it may receive three kinds of one-cycle error report, each with the address of the failing access: a corrected single-bit error, an uncorrectable error and an address parity error. Every single-bit correction advances an occurrence counter. When the counter reaches a programmable threshold, the block raises a single-bit event. Uncorrectable and parity errors raise their events directly. Each event sets a sticky status flag. An interrupt is driven whenever a flag is set and its enable bit is on. The address of the first event of each kind is held in a capture register until software reads that register.

A debug-mode input changes how the block behaves. While it is high, corrections are still counted. No status flag is set, no address is captured, and a read of a capture register no longer empties it, so an address captured before debug entry survives any number of debug-time reads.

Software sees the block through a small word-indexed register port. A read returns its data on the cycle after the strobe.

Top module: `ram_err_logger`

## Requirements
- R1: After reset, the status flags, counter, threshold, enables and all three capture registers are zero, and all interrupts are low.
- R2: Each `sbe_valid` pulse adds one to the counter (register index 3), in debug mode as well. The counter saturates at all-ones. Writing index 3 loads the counter.
- R3: Outside debug, with a nonzero threshold (index 2), a correction that brings the counter to a value at or above the threshold does three things: it sets status bit 0, it returns the counter to zero, and it captures the address in the single-bit capture register (index 4) if that register is empty.
- R4: With a threshold of zero, corrections are counted but never set status bit 0.
- R5: Outside debug, a `ube_valid` pulse sets status bit 1 and captures `ube_addr` in index 5 if that register is empty. A full register keeps the first address.
- R6: Outside debug, an `ape_valid` pulse sets status bit 2 and captures `ape_addr` in index 6 if that register is empty.
- R7: In debug mode, no report of any kind sets a status flag or changes a capture register.
- R8: A capture register reads as bit 31 = 1 (holding) with the address in the low bits. A read outside debug empties it, so the next read returns 0. A read in debug leaves it unchanged.
- R9: Status (index 1) is write-1-to-clear on bits [2:0]. A new event in the same cycle wins over the clear.
- R10: Each interrupt is high exactly when its status bit and the matching enable bit (index 0, bits [2:0] = single-bit, uncorrectable, parity) are both set.
- R11: Read data appears on `reg_rdata` one cycle after a `reg_rd` strobe. Threshold and enables read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Debug mode: suppresses events, captures and read clearing |
| sbe_valid | input | 1 | Single-bit correction report |
| sbe_addr | input | ADDR_W | Address of the corrected access |
| ube_valid | input | 1 | Uncorrectable error report |
| ube_addr | input | ADDR_W | Address of the uncorrectable access |
| ape_valid | input | 1 | Address parity error report |
| ape_addr | input | ADDR_W | Address of the parity-failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq_sbe | output | 1 | Single-bit threshold interrupt |
| irq_ube | output | 1 | Uncorrectable error interrupt |
| irq_ape | output | 1 | Address parity interrupt |

## Verification
The bench drives a counter past the threshold inside debug and then leaves debug. A design that compared for equality instead of at-or-above would then never raise the single-bit event. It reads a capture register twice in debug and twice after leaving debug. A design that cleared on every read would lose the frozen address, and one that ignored debug would capture the debug-time reports. It also sends two uncorrectable reports back to back, to catch a design that overwrites the held address. Finally it runs the counter with a zero threshold and at its all-ones limit, where a missing guard would either raise an event or wrap to zero.

// File: rtl/ram_err_pkg.sv
package ram_err_pkg;
   localparam int NSRC      = 3;
   localparam int SRC_SBE   = 0;
   localparam int SRC_UBE   = 1;
   localparam int SRC_APE   = 2;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      RG_CTRL    = 3'd0,
      RG_STATUS  = 3'd1,
      RG_THRESH  = 3'd2,
      RG_COUNT   = 3'd3,
      RG_SBE_ADR = 3'd4,
      RG_UBE_ADR = 3'd5,
      RG_APE_ADR = 3'd6
   } reg_idx_e;

   function automatic logic [REG_IDX_W-1:0] cap_reg_of(input int src);
      case (src)
         SRC_SBE: return RG_SBE_ADR;
         SRC_UBE: return RG_UBE_ADR;
         default: return RG_APE_ADR;
      endcase
   endfunction
endpackage

// File: rtl/rel_corr_counter.sv
module rel_corr_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dbg,
   input  logic [CNT_W-1:0] thresh,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (count_q == {CNT_W{1'b1}}) ? count_q : count_q + 1'b1;
      end else begin : g_wrap
         assign nxt = count_q + 1'b1;
      end
   endgenerate

   assign hit   = inc && !dbg && (thresh != '0) && (nxt >= thresh);
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (wr_en) begin
         count_q <= wr_val;
      end else if (hit) begin
         count_q <= '0;
      end else if (inc) begin
         count_q <= nxt;
      end
   end
endmodule

// File: rtl/rel_addr_capture.sv
module rel_addr_capture #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg,
   input  logic              evt,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              rd_hit,
   output logic              vld,
   output logic [ADDR_W-1:0] addr_q
);
   logic rd_take;
   logic cap;

   assign rd_take = rd_hit && !dbg;
   assign cap     = evt && !dbg && (!vld || rd_take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         addr_q <= '0;
      end else if (cap) begin
         vld    <= 1'b1;
         addr_q <= addr_in;
      end else if (rd_take) begin
         vld    <= 1'b0;
         addr_q <= '0;
      end
   end
endmodule

// File: rtl/rel_regfile.sv
module rel_regfile
   import ram_err_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic [NSRC-1:0]      sts_set,
   input  logic [CNT_W-1:0]     count,
   input  logic [NSRC-1:0]      cap_vld,
   input  logic [ADDR_W-1:0]    cap_addr [NSRC],
   output logic [NSRC-1:0]      en,
   output logic [CNT_W-1:0]     thresh,
   output logic [NSRC-1:0]      sts,
   output logic [DATA_W-1:0]    rdata,
   output logic                 cnt_wr,
   output logic [NSRC-1:0]      rd_hit
);
   logic [NSRC-1:0]   w1c;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] cap_word [NSRC];

   assign cnt_wr = reg_wr && (reg_addr == RG_COUNT);
   assign w1c    = (reg_wr && (reg_addr == RG_STATUS)) ? reg_wdata[NSRC-1:0] : '0;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign rd_hit[i] = reg_rd && (reg_addr == cap_reg_of(i));
         always_comb begin
            cap_word[i]              = '0;
            cap_word[i][DATA_W-1]    = cap_vld[i];
            cap_word[i][ADDR_W-1:0]  = cap_addr[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         thresh <= '0;
         sts    <= '0;
      end else begin
         if (reg_wr && (reg_addr == RG_CTRL))   en     <= reg_wdata[NSRC-1:0];
         if (reg_wr && (reg_addr == RG_THRESH)) thresh <= reg_wdata[CNT_W-1:0];
         sts <= (sts & ~w1c) | sts_set;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         RG_CTRL:    rd_mux[NSRC-1:0]  = en;
         RG_STATUS:  rd_mux[NSRC-1:0]  = sts;
         RG_THRESH:  rd_mux[CNT_W-1:0] = thresh;
         RG_COUNT:   rd_mux[CNT_W-1:0] = count;
         RG_SBE_ADR: rd_mux            = cap_word[SRC_SBE];
         RG_UBE_ADR: rd_mux            = cap_word[SRC_UBE];
         RG_APE_ADR: rd_mux            = cap_word[SRC_APE];
         default:    rd_mux            = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (reg_rd) begin
         rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/ram_err_logger.sv
module ram_err_logger
   import ram_err_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dbg_mode,
   input  logic                 sbe_valid,
   input  logic [ADDR_W-1:0]    sbe_addr,
   input  logic                 ube_valid,
   input  logic [ADDR_W-1:0]    ube_addr,
   input  logic                 ape_valid,
   input  logic [ADDR_W-1:0]    ape_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 irq_sbe,
   output logic                 irq_ube,
   output logic                 irq_ape
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must leave bit DATA_W-1 free for the holding flag");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must fit in one register word");
      end
   endgenerate

   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  thr_q;
   logic              cnt_wr;
   logic              thr_hit;
   logic [NSRC-1:0]   en_q;
   logic [NSRC-1:0]   sts_q;
   logic [NSRC-1:0]   sts_set;
   logic [NSRC-1:0]   cap_evt;
   logic [NSRC-1:0]   cap_vld;
   logic [NSRC-1:0]   rd_hit;
   logic [ADDR_W-1:0] cap_addr [NSRC];
   logic [ADDR_W-1:0] src_addr [NSRC];

   rel_corr_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (sbe_valid),
      .dbg    (dbg_mode),
      .thresh (thr_q),
      .wr_en  (cnt_wr),
      .wr_val (reg_wdata[CNT_W-1:0]),
      .count  (count_q),
      .hit    (thr_hit)
   );

   assign cap_evt[SRC_SBE]  = thr_hit;
   assign cap_evt[SRC_UBE]  = ube_valid && !dbg_mode;
   assign cap_evt[SRC_APE]  = ape_valid && !dbg_mode;
   assign src_addr[SRC_SBE] = sbe_addr;
   assign src_addr[SRC_UBE] = ube_addr;
   assign src_addr[SRC_APE] = ape_addr;
   assign sts_set           = cap_evt;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_cap
         rel_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .dbg     (dbg_mode),
            .evt     (cap_evt[i]),
            .addr_in (src_addr[i]),
            .rd_hit  (rd_hit[i]),
            .vld     (cap_vld[i]),
            .addr_q  (cap_addr[i])
         );
      end
   endgenerate

   rel_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .sts_set   (sts_set),
      .count     (count_q),
      .cap_vld   (cap_vld),
      .cap_addr  (cap_addr),
      .en        (en_q),
      .thresh    (thr_q),
      .sts       (sts_q),
      .rdata     (reg_rdata),
      .cnt_wr    (cnt_wr),
      .rd_hit    (rd_hit)
   );

   assign irq_sbe = sts_q[SRC_SBE] & en_q[SRC_SBE];
   assign irq_ube = sts_q[SRC_UBE] & en_q[SRC_UBE];
   assign irq_ape = sts_q[SRC_APE] & en_q[SRC_APE];
endmodule

// File: rtl/ram_err_logger_chk.sv
module ram_err_logger_chk
   import ram_err_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dbg_mode,
   input logic                 sbe_valid,
   input logic                 ube_valid,
   input logic                 reg_rd,
   input logic [REG_IDX_W-1:0] reg_addr,
   input logic                 cnt_wr,
   input logic [CNT_W-1:0]     count_q,
   input logic [CNT_W-1:0]     thr_q,
   input logic [NSRC-1:0]      sts_q,
   input logic                 ube_vld,
   input logic [ADDR_W-1:0]    ube_cap,
   input logic                 ape_vld,
   input logic [ADDR_W-1:0]    ape_cap
);
   // R2
   count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sbe_valid && !cnt_wr) |=> $stable(count_q));

   // R5
   ube_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ube_valid && !dbg_mode) |=> sts_q[SRC_UBE]);

   // R7
   dbg_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode && (sts_q == '0)) |=> (sts_q == '0));

   // R8
   dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode && ube_vld) |=> (ube_vld && $stable(ube_cap)));

   // R6
   ape_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ape_vld && !(reg_rd && reg_addr == RG_APE_ADR)) |=> (ape_vld && $stable(ape_cap)));

   // R4
   zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_q == '0) && !sts_q[SRC_SBE]) |=> !sts_q[SRC_SBE]);
endmodule

bind ram_err_logger ram_err_logger_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dbg_mode  (dbg_mode),
   .sbe_valid (sbe_valid),
   .ube_valid (ube_valid),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .cnt_wr    (cnt_wr),
   .count_q   (count_q),
   .thr_q     (thr_q),
   .sts_q     (sts_q),
   .ube_vld   (cap_vld[1]),
   .ube_cap   (cap_addr[1]),
   .ape_vld   (cap_vld[2]),
   .ape_cap   (cap_addr[2])
);

// File: tb/ram_err_logger_tb.sv
`timescale 1ns/1ps
module ram_err_logger_tb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NV = 12;

   // entry: {kind[1:0], dbg, addr[15:0], exp_status[2:0], exp_count[15:0]}
   localparam logic [37:0] VEC [NV] = '{
      {2'd0, 1'b0, 16'h1111, 3'b000, 16'd1},
      {2'd0, 1'b0, 16'h1112, 3'b000, 16'd2},
      {2'd0, 1'b0, 16'h1113, 3'b001, 16'd0},
      {2'd1, 1'b0, 16'h2220, 3'b010, 16'd0},
      {2'd2, 1'b0, 16'h3330, 3'b100, 16'd0},
      {2'd0, 1'b1, 16'h1114, 3'b000, 16'd1},
      {2'd1, 1'b1, 16'h2221, 3'b000, 16'd1},
      {2'd2, 1'b1, 16'h3331, 3'b000, 16'd1},
      {2'd0, 1'b1, 16'h1115, 3'b000, 16'd2},
      {2'd0, 1'b1, 16'h1116, 3'b000, 16'd3},
      {2'd0, 1'b1, 16'h1117, 3'b000, 16'd4},
      {2'd0, 1'b0, 16'h1118, 3'b001, 16'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dbg_mode = 1'b0;
   logic          sbe_valid = 1'b0, ube_valid = 1'b0, ape_valid = 1'b0;
   logic [AW-1:0] sbe_addr = '0, ube_addr = '0, ape_addr = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_sbe, irq_ube, irq_ape;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [DW-1:0] rd;

   always #2 clk = ~clk;

   ram_err_logger u_dut (
      .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
      .sbe_valid(sbe_valid), .sbe_addr(sbe_addr),
      .ube_valid(ube_valid), .ube_addr(ube_addr),
      .ape_valid(ape_valid), .ape_addr(ape_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_sbe(irq_sbe), .irq_ube(irq_ube), .irq_ape(irq_ape)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic inject(input logic [1:0] kind, input logic [AW-1:0] a);
      case (kind)
         2'd0: begin sbe_valid = 1'b1; sbe_addr = a; end
         2'd1: begin ube_valid = 1'b1; ube_addr = a; end
         default: begin ape_valid = 1'b1; ape_addr = a; end
      endcase
      @(negedge clk);
      sbe_valid = 1'b0; ube_valid = 1'b0; ape_valid = 1'b0;
   endtask

   task automatic reg_write(input logic [2:0] idx, input logic [DW-1:0] d);
      reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] idx, output logic [DW-1:0] d);
      reg_rd = 1'b1; reg_addr = idx;
      @(posedge clk);
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_read(3'd1, rd); check("R1 status", rd, 32'h0);
      reg_read(3'd3, rd); check("R1 count", rd, 32'h0);
      reg_read(3'd5, rd); check("R1 ube capture", rd, 32'h0);
      check("R1 irqs", {29'h0, irq_sbe, irq_ube, irq_ape}, 32'h0);

      // R11 readback
      reg_write(3'd0, 32'h7);
      reg_write(3'd2, 32'd3);
      reg_read(3'd2, rd); check("R11 threshold", rd, 32'd3);
      reg_read(3'd0, rd); check("R11 enables", rd, 32'h7);

      // R3 R5 R6 R7 table walk
      for (int i = 0; i < NV; i++) begin
         dbg_mode = VEC[i][35];
         inject(VEC[i][37:36], VEC[i][34:19]);
         reg_read(3'd1, rd);
         check(VEC[i][35] ? "R7 status" : "R3/R5/R6 status", rd, {29'h0, VEC[i][18:16]});
         reg_read(3'd3, rd);
         check("R2/R3 count", rd, {16'h0, VEC[i][15:0]});
         reg_write(3'd1, 32'h7);
         dbg_mode = 1'b0;
      end

      // R8 capture contents and clear-on-read
      reg_read(3'd4, rd); check("R3 sbe capture", rd, 32'h8000_1113);
      reg_read(3'd4, rd); check("R8 sbe cleared", rd, 32'h0);
      reg_read(3'd5, rd); check("R7 ube capture", rd, 32'h8000_2220);
      reg_read(3'd5, rd); check("R8 ube cleared", rd, 32'h0);
      reg_read(3'd6, rd); check("R6 ape capture", rd, 32'h8000_3330);

      // R5 first address held, R8 frozen in debug
      inject(2'd1, 16'h4440);
      inject(2'd1, 16'h4441);
      dbg_mode = 1'b1;
      reg_read(3'd5, rd); check("R8 debug read 1", rd, 32'h8000_4440);
      reg_read(3'd5, rd); check("R8 debug read 2", rd, 32'h8000_4440);
      dbg_mode = 1'b0;
      reg_read(3'd5, rd); check("R5 held first", rd, 32'h8000_4440);
      reg_read(3'd5, rd); check("R8 cleared after debug", rd, 32'h0);

      // R10 interrupt gating
      check("R10 irq_ube on", {31'h0, irq_ube}, 32'h1);
      reg_write(3'd0, 32'h5);
      check("R10 irq_ube masked", {31'h0, irq_ube}, 32'h0);
      reg_write(3'd0, 32'h7);
      check("R10 irq_ube unmasked", {31'h0, irq_ube}, 32'h1);
      reg_write(3'd1, 32'h2);
      check("R9 w1c irq", {31'h0, irq_ube}, 32'h0);
      reg_read(3'd1, rd); check("R9 w1c status", rd, 32'h0);

      // R9 event wins over simultaneous clear
      ape_valid = 1'b1; ape_addr = 16'h5550;
      reg_write(3'd1, 32'h4);
      ape_valid = 1'b0;
      reg_read(3'd1, rd); check("R9 set wins", rd, 32'h4);
      check("R10 irq_ape", {31'h0, irq_ape}, 32'h1);
      reg_write(3'd1, 32'h7);

      // R4 zero threshold
      reg_write(3'd2, 32'd0);
      reg_write(3'd3, 32'd0);
      for (int k = 0; k < 5; k++) inject(2'd0, 16'h6660);
      reg_read(3'd3, rd); check("R4 count", rd, 32'd5);
      reg_read(3'd1, rd); check("R4 no flag", rd, 32'h0);
      check("R4 no irq", {31'h0, irq_sbe}, 32'h0);

      // R2 saturation
      reg_write(3'd3, 32'h0000_FFFE);
      for (int k = 0; k < 3; k++) inject(2'd0, 16'h7770);
      reg_read(3'd3, rd); check("R2 saturate", rd, 32'h0000_FFFF);

      finish_run();
   end
endmodule